// File: doc/BRIEF.md
# Abort Fault Status Capture Unit

When a processor takes an abort, the handler needs a record of what went wrong: the kind of fault, which access caused it, where in the memory system the error was found, and where execution should resume. This unit sits beside the exception logic and takes that snapshot. It accepts two event channels. The synchronous channel carries instruction-side and data-side aborts and debug events, together with the faulting address. The asynchronous channel carries imprecise errors reported later by the memory system, together with the cache set where one applies.

For each side the unit keeps a status word, an address word and an auxiliary word, and it also keeps a return address and a saved state word. Which words change depends on the event class. Synchronous aborts record the address but never a cache index. Asynchronous aborts touch only the data-side status and auxiliary words, plus the return and state words, and they record the cache set. If both channels fire in the same cycle, the synchronous event is captured first and the asynchronous one a cycle later. The handler reads every word through a 3-bit select with one cycle of latency, and it clears a status word's valid flag by writing to that select.

Top module: `abort_fault_capture`

## Requirements
- R1: Every captured event (synchronous, asynchronous or debug) loads the return-address word from `exc_ret_addr` and the saved-state word from `exc_state`, both sampled in the capture cycle.
- R2: A synchronous event updates only the status word of its own side (`sync_side` 0 = instruction, 1 = data). The status layout is: bits [4:0] fault code, bit 5 write flag, bits [7:6] class, and all other bits zero.
- R3: The status class field reads 0 for a synchronous abort, 1 for an asynchronous abort and 2 for a debug event.
- R4: A synchronous non-debug abort loads the address word of its own side with `sync_addr`. The other side's address word is unchanged.
- R5: A synchronous non-debug abort loads its side's auxiliary word with the recoverable flag, the location and the way. Its set field is stored as zero.
- R6: An asynchronous abort updates the data-side status and auxiliary words only. The data address word and all instruction-side words keep their values.
- R7: The auxiliary layout is: bit 0 recoverable, bits [2:1] location (0 = cache, 1 = bus master interface, 2 = tightly-coupled memory A, 3 = tightly-coupled memory B), bits [4+:WAY_W] way and bits [8+:SET_W] set. The way and set fields read zero whenever the location is not the cache.
- R8: A debug event updates the status word of its side and the return and state words. The address and auxiliary words are unchanged.
- R9: All valid flags are zero after reset and become one on capture. A write (`wr_en`) with `wr_sel` 0 or 1 clears that status word's valid flag. A write to any other select has no effect. A capture into a status word in the same cycle as a clear of it leaves the flag set.
- R10: When the synchronous and asynchronous channels fire in the same cycle, the synchronous event is captured at that edge. The asynchronous event is captured at the next edge, with return and state taken from that later cycle.
- R11: Select map: 0/1 instruction/data status, 2/3 instruction/data address, 4/5 instruction/data auxiliary, 6 return address, 7 saved state. `rd_valid` and `rd_data` show the selected word one cycle after `rd_sel` is sampled, zero-extended, and both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_valid | input | 1 | Synchronous event strobe |
| sync_side | input | 1 | 0 instruction side, 1 data side |
| sync_debug | input | 1 | Event is a debug event |
| sync_write | input | 1 | Faulting access was a write |
| sync_code | input | CODE_W | Fault type code |
| sync_addr | input | AW | Faulting access address |
| sync_recov | input | 1 | Error is recoverable |
| sync_loc | input | 2 | Error location |
| sync_way | input | WAY_W | Cache way of the error |
| async_valid | input | 1 | Asynchronous abort strobe |
| async_write | input | 1 | Faulting access was a write |
| async_code | input | CODE_W | Fault type code |
| async_recov | input | 1 | Error is recoverable |
| async_loc | input | 2 | Error location |
| async_set | input | SET_W | Cache set of the error |
| async_way | input | WAY_W | Cache way of the error |
| exc_ret_addr | input | AW | Return address of the taken exception |
| exc_state | input | SW | State word to save |
| wr_en | input | 1 | Handler write strobe |
| wr_sel | input | 3 | Handler write select |
| rd_sel | input | 3 | Read select |
| rd_valid | output | 1 | Valid flag of the word read |
| rd_data | output | DW | Word read |

## Verification
A fault in the capture-enable decode shows up as a stale or overwritten word on the very next read of that select. An asynchronous abort that wrongly touches the data address, or a synchronous abort that leaks a set index, is caught one read after the event. A fault in the hold slot shows up in the two reads after a collision: the first return word read must still be the synchronous one, and the second must hold the value present on the next cycle. A valid flag stuck at one or zero shows at the first status read after a clear or a capture, so every fault injected into the state is visible within two cycles of the stimulus that exposes it.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic [1:0] {
      CLS_SYNC  = 2'd0,
      CLS_ASYNC = 2'd1,
      CLS_DEBUG = 2'd2
   } fault_cls_e;

   typedef enum logic [1:0] {
      LOC_CACHE = 2'd0,
      LOC_BUS   = 2'd1,
      LOC_TCM_A = 2'd2,
      LOC_TCM_B = 2'd3
   } err_loc_e;

   // status word field positions
   localparam int unsigned ST_CODE_MAX = 5;
   localparam int unsigned ST_WR_BIT   = 5;
   localparam int unsigned ST_CLS_LSB  = 6;

   // auxiliary word field positions
   localparam int unsigned AUX_RECOV_BIT = 0;
   localparam int unsigned AUX_LOC_LSB   = 1;
   localparam int unsigned AUX_WAY_LSB   = 4;
   localparam int unsigned AUX_WAY_MAX   = 4;
   localparam int unsigned AUX_SET_LSB   = 8;

   // read select map
   localparam int unsigned NUM_WORDS = 8;
   localparam int unsigned SEL_RET   = 6;
   localparam int unsigned SEL_STATE = 7;

endpackage

// File: rtl/afc_pending.sv
module afc_pending #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_valid,
   input  logic          async_valid,
   input  logic [PW-1:0] in_pkt,
   output logic          async_go,
   output logic          pend_v,
   output logic [PW-1:0] go_pkt
);

   logic [PW-1:0] pend_q;

   assign async_go = !sync_valid && (pend_v || async_valid);
   assign go_pkt   = pend_v ? pend_q : in_pkt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_q <= '0;
      end else if (sync_valid) begin
         if (async_valid) begin
            pend_v <= 1'b1;
            pend_q <= in_pkt;
         end
      end else if (pend_v) begin
         pend_v <= async_valid;
         if (async_valid) pend_q <= in_pkt;
      end else begin
         pend_v <= 1'b0;
      end
   end

endmodule

// File: rtl/afc_side_regs.sv
module afc_side_regs #(
   parameter int AW     = 32,
   parameter int CODE_W = 5,
   parameter int WAY_W  = 2,
   parameter int SET_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_we,
   input  logic [1:0]        st_cls_d,
   input  logic              st_wr_d,
   input  logic [CODE_W-1:0] st_code_d,
   input  logic              st_clr,
   input  logic              addr_we,
   input  logic [AW-1:0]     addr_d,
   input  logic              aux_we,
   input  logic              aux_recov_d,
   input  logic [1:0]        aux_loc_d,
   input  logic [WAY_W-1:0]  aux_way_d,
   input  logic [SET_W-1:0]  aux_set_d,
   output logic              st_v,
   output logic [1:0]        st_cls,
   output logic              st_wr,
   output logic [CODE_W-1:0] st_code,
   output logic              addr_v,
   output logic [AW-1:0]     addr_q,
   output logic              aux_v,
   output logic              aux_recov,
   output logic [1:0]        aux_loc,
   output logic [WAY_W-1:0]  aux_way,
   output logic [SET_W-1:0]  aux_set
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_v    <= 1'b0;
         st_cls  <= '0;
         st_wr   <= 1'b0;
         st_code <= '0;
      end else if (st_we) begin
         st_v    <= 1'b1;
         st_cls  <= st_cls_d;
         st_wr   <= st_wr_d;
         st_code <= st_code_d;
      end else if (st_clr) begin
         st_v    <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_v <= 1'b0;
         addr_q <= '0;
      end else if (addr_we) begin
         addr_v <= 1'b1;
         addr_q <= addr_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aux_v     <= 1'b0;
         aux_recov <= 1'b0;
         aux_loc   <= '0;
         aux_way   <= '0;
         aux_set   <= '0;
      end else if (aux_we) begin
         aux_v     <= 1'b1;
         aux_recov <= aux_recov_d;
         aux_loc   <= aux_loc_d;
         aux_way   <= aux_way_d;
         aux_set   <= aux_set_d;
      end
   end

endmodule

// File: rtl/afc_read_port.sv
module afc_read_port #(
   parameter  int NREG  = 8,
   parameter  int DW    = 32,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SEL_W-1:0]      sel,
   input  logic [NREG-1:0][DW:0] words,
   output logic                  rd_valid,
   output logic [DW-1:0]         rd_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         {rd_valid, rd_data} <= words[sel];
      end
   end

endmodule

// File: rtl/abort_fault_capture.sv
module abort_fault_capture
   import afc_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int SW     = 32,
   parameter int CODE_W = 5,
   parameter int WAY_W  = 2,
   parameter int SET_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_valid,
   input  logic              sync_side,
   input  logic              sync_debug,
   input  logic              sync_write,
   input  logic [CODE_W-1:0] sync_code,
   input  logic [AW-1:0]     sync_addr,
   input  logic              sync_recov,
   input  logic [1:0]        sync_loc,
   input  logic [WAY_W-1:0]  sync_way,
   input  logic              async_valid,
   input  logic              async_write,
   input  logic [CODE_W-1:0] async_code,
   input  logic              async_recov,
   input  logic [1:0]        async_loc,
   input  logic [SET_W-1:0]  async_set,
   input  logic [WAY_W-1:0]  async_way,
   input  logic [AW-1:0]     exc_ret_addr,
   input  logic [SW-1:0]     exc_state,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [2:0]        rd_sel,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data
);

   localparam int PW = CODE_W + 1 + 1 + 2 + WAY_W + SET_W;

   // elaboration-time parameter checks
   if (CODE_W > ST_CODE_MAX) begin : g_bad_code
      $error("CODE_W exceeds status code field");
   end
   if (WAY_W > AUX_WAY_MAX) begin : g_bad_way
      $error("WAY_W exceeds auxiliary way field");
   end
   if (AUX_SET_LSB + SET_W > DW) begin : g_bad_set
      $error("SET_W does not fit the read word");
   end
   if (AW > DW || SW > DW) begin : g_bad_width
      $error("address or state wider than the read word");
   end

   function automatic logic [DW-1:0] fmt_status(input logic [1:0] cls, input logic wr,
                                                input logic [CODE_W-1:0] code);
      logic [DW-1:0] r;
      r = '0;
      r[CODE_W-1:0] = code;
      r[ST_WR_BIT] = wr;
      r[ST_CLS_LSB +: 2] = cls;
      return r;
   endfunction

   function automatic logic [DW-1:0] fmt_aux(input logic recov, input logic [1:0] loc,
                                             input logic [WAY_W-1:0] way,
                                             input logic [SET_W-1:0] set);
      logic [DW-1:0] r;
      r = '0;
      r[AUX_RECOV_BIT] = recov;
      r[AUX_LOC_LSB +: 2] = loc;
      if (loc == LOC_CACHE) begin
         r[AUX_WAY_LSB +: WAY_W] = way;
         r[AUX_SET_LSB +: SET_W] = set;
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] widen_addr(input logic [AW-1:0] a);
      logic [DW-1:0] r;
      r = '0;
      r[AW-1:0] = a;
      return r;
   endfunction

   function automatic logic [DW-1:0] widen_state(input logic [SW-1:0] s);
      logic [DW-1:0] r;
      r = '0;
      r[SW-1:0] = s;
      return r;
   endfunction

   // asynchronous hold slot
   logic              async_go;
   logic              pend_v;
   logic [PW-1:0]     go_pkt;
   logic              a_wr, a_recov;
   logic [CODE_W-1:0] a_code;
   logic [1:0]        a_loc;
   logic [WAY_W-1:0]  a_way;
   logic [SET_W-1:0]  a_set;

   afc_pending #(.PW(PW)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_valid (sync_valid),
      .async_valid(async_valid),
      .in_pkt     ({async_code, async_write, async_recov, async_loc, async_way, async_set}),
      .async_go   (async_go),
      .pend_v     (pend_v),
      .go_pkt     (go_pkt)
   );

   assign {a_code, a_wr, a_recov, a_loc, a_way, a_set} = go_pkt;

   // per-side register sets
   logic [1:0]                   st_v, st_wr, addr_v, aux_v, aux_recov;
   logic [1:0][1:0]              st_cls, aux_loc;
   logic [1:0][CODE_W-1:0]       st_code;
   logic [1:0][AW-1:0]           side_addr;
   logic [1:0][WAY_W-1:0]        aux_way;
   logic [1:0][SET_W-1:0]        aux_set;
   logic [NUM_WORDS-1:0][DW:0]   rd_words;

   for (genvar g = 0; g < 2; g++) begin : g_side
      localparam bit IS_D = (g == 1);
      logic       sv, a_here;
      logic [1:0] cls_d;

      assign sv     = sync_valid && (sync_side == IS_D);
      assign a_here = IS_D && async_go;
      assign cls_d  = sv ? (sync_debug ? CLS_DEBUG : CLS_SYNC) : CLS_ASYNC;

      afc_side_regs #(.AW(AW), .CODE_W(CODE_W), .WAY_W(WAY_W), .SET_W(SET_W)) u_regs (
         .clk        (clk),
         .rst_n      (rst_n),
         .st_we      (sv || a_here),
         .st_cls_d   (cls_d),
         .st_wr_d    (sv ? sync_write : a_wr),
         .st_code_d  (sv ? sync_code : a_code),
         .st_clr     (wr_en && (wr_sel == 3'(g))),
         .addr_we    (sv && !sync_debug),
         .addr_d     (sync_addr),
         .aux_we     ((sv && !sync_debug) || a_here),
         .aux_recov_d(sv ? sync_recov : a_recov),
         .aux_loc_d  (sv ? sync_loc : a_loc),
         .aux_way_d  (sv ? sync_way : a_way),
         .aux_set_d  (sv ? '0 : a_set),
         .st_v       (st_v[g]),
         .st_cls     (st_cls[g]),
         .st_wr      (st_wr[g]),
         .st_code    (st_code[g]),
         .addr_v     (addr_v[g]),
         .addr_q     (side_addr[g]),
         .aux_v      (aux_v[g]),
         .aux_recov  (aux_recov[g]),
         .aux_loc    (aux_loc[g]),
         .aux_way    (aux_way[g]),
         .aux_set    (aux_set[g])
      );

      assign rd_words[g]     = {st_v[g], fmt_status(st_cls[g], st_wr[g], st_code[g])};
      assign rd_words[2 + g] = {addr_v[g], widen_addr(side_addr[g])};
      assign rd_words[4 + g] = {aux_v[g], fmt_aux(aux_recov[g], aux_loc[g], aux_way[g], aux_set[g])};
   end

   // return address and saved state
   logic          ret_v;
   logic [AW-1:0] ret_q;
   logic [SW-1:0] state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_v   <= 1'b0;
         ret_q   <= '0;
         state_q <= '0;
      end else if (sync_valid || async_go) begin
         ret_v   <= 1'b1;
         ret_q   <= exc_ret_addr;
         state_q <= exc_state;
      end
   end

   assign rd_words[SEL_RET]   = {ret_v, widen_addr(ret_q)};
   assign rd_words[SEL_STATE] = {ret_v, widen_state(state_q)};

   afc_read_port #(.NREG(NUM_WORDS), .DW(DW)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (rd_sel),
      .words   (rd_words),
      .rd_valid(rd_valid),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
   parameter int AW    = 32,
   parameter int SET_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_valid,
   input logic             sync_side,
   input logic             sync_debug,
   input logic [AW-1:0]    sync_addr,
   input logic             async_valid,
   input logic             async_go,
   input logic             wr_en,
   input logic [2:0]       wr_sel,
   input logic [AW-1:0]    exc_ret_addr,
   input logic [AW-1:0]    ret_q,
   input logic [AW-1:0]    iaddr,
   input logic [AW-1:0]    daddr,
   input logic [SET_W-1:0] iset,
   input logic [SET_W-1:0] dset,
   input logic             ist_v,
   input logic             dst_v
);

   p_ret_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid || async_go) |=> ret_q == $past(exc_ret_addr));

   p_iaddr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid && !sync_side && !sync_debug) |=> iaddr == $past(sync_addr));

   p_daddr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid && sync_side && !sync_debug) |=> daddr == $past(sync_addr));

   p_iaddr_other_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid && sync_side) |=> $stable(iaddr));

   p_sync_no_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid && sync_side && !sync_debug) |=> dset == '0);

   p_iset_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iset == '0);

   p_async_keeps_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      async_go |=> ($stable(daddr) && $stable(iaddr)));

   p_debug_keeps_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid && sync_debug) |=> ($stable(daddr) && $stable(iaddr)));

   p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd0 && !(sync_valid && !sync_side)) |=> !ist_v);

   p_capture_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid && sync_side) |=> dst_v);

   p_collision_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_valid && async_valid) |=> async_go);

endmodule

bind abort_fault_capture afc_checker #(.AW(AW), .SET_W(SET_W)) u_afc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_valid  (sync_valid),
   .sync_side   (sync_side),
   .sync_debug  (sync_debug),
   .sync_addr   (sync_addr),
   .async_valid (async_valid),
   .async_go    (async_go),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .exc_ret_addr(exc_ret_addr),
   .ret_q       (ret_q),
   .iaddr       (side_addr[0]),
   .daddr       (side_addr[1]),
   .iset        (aux_set[0]),
   .dset        (aux_set[1]),
   .ist_v       (st_v[0]),
   .dst_v       (st_v[1])
);

// File: tb/tb_abort_fault_capture.sv
`timescale 1ns/1ps
module tb_abort_fault_capture;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_valid = 0, sync_side = 0, sync_debug = 0, sync_write = 0;
   logic [4:0]  sync_code = '0;
   logic [31:0] sync_addr = '0;
   logic        sync_recov = 0;
   logic [1:0]  sync_loc = '0;
   logic [1:0]  sync_way = '0;
   logic        async_valid = 0, async_write = 0, async_recov = 0;
   logic [4:0]  async_code = '0;
   logic [1:0]  async_loc = '0;
   logic [7:0]  async_set = '0;
   logic [1:0]  async_way = '0;
   logic [31:0] exc_ret_addr = '0;
   logic [31:0] exc_state = '0;
   logic        wr_en = 0;
   logic [2:0]  wr_sel = '0;
   logic [2:0]  rd_sel = '0;
   logic        rd_valid;
   logic [31:0] rd_data;

   always #2 clk = ~clk;

   abort_fault_capture dut (
      .clk(clk), .rst_n(rst_n),
      .sync_valid(sync_valid), .sync_side(sync_side), .sync_debug(sync_debug),
      .sync_write(sync_write), .sync_code(sync_code), .sync_addr(sync_addr),
      .sync_recov(sync_recov), .sync_loc(sync_loc), .sync_way(sync_way),
      .async_valid(async_valid), .async_write(async_write), .async_code(async_code),
      .async_recov(async_recov), .async_loc(async_loc), .async_set(async_set),
      .async_way(async_way), .exc_ret_addr(exc_ret_addr), .exc_state(exc_state),
      .wr_en(wr_en), .wr_sel(wr_sel), .rd_sel(rd_sel),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   typedef struct {
      logic [2:0]  sel;
      logic        v;
      logic [31:0] d;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   // monitor: compares the word for a select driven before the last edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (rd_valid !== e.v || rd_data !== e.d) begin
            errors++;
            $display("FAIL %s sel=%0d: got v=%0b d=%h, expected v=%0b d=%h",
                     e.tag, e.sel, rd_valid, rd_data, e.v, e.d);
         end
      end
   end

   task automatic rd(input logic [2:0] s, input logic v, input logic [31:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      sync_valid = 0; async_valid = 0; wr_en = 0;
      rd_sel = s;
      e.sel = s; e.v = v; e.d = d; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic ev_sync(input logic side, input logic dbg, input logic wr, input logic [4:0] code,
                          input logic [31:0] addr, input logic recov, input logic [1:0] loc,
                          input logic [1:0] way, input logic [31:0] ret, input logic [31:0] st);
      @(negedge clk);
      sync_valid = 1; sync_side = side; sync_debug = dbg; sync_write = wr;
      sync_code = code; sync_addr = addr; sync_recov = recov; sync_loc = loc;
      sync_way = way; exc_ret_addr = ret; exc_state = st;
   endtask

   task automatic set_async(input logic wr, input logic [4:0] code, input logic recov,
                            input logic [1:0] loc, input logic [7:0] set, input logic [1:0] way);
      async_valid = 1; async_write = wr; async_code = code; async_recov = recov;
      async_loc = loc; async_set = set; async_way = way;
   endtask

   task automatic ev_async(input logic wr, input logic [4:0] code, input logic recov,
                           input logic [1:0] loc, input logic [7:0] set, input logic [1:0] way,
                           input logic [31:0] ret, input logic [31:0] st);
      @(negedge clk);
      set_async(wr, code, recov, loc, set, way);
      exc_ret_addr = ret; exc_state = st;
   endtask

   task automatic hw_write(input logic [2:0] s);
      @(negedge clk);
      wr_en = 1; wr_sel = s;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;

      // reset state
      for (int i = 0; i < 8; i++) rd(3'(i), 0, 32'h0, "R9 R11 reset");

      // synchronous instruction-side read abort in memory A
      ev_sync(0, 0, 0, 5'h0D, 32'h1000_0040, 1, 2'd2, 2'd1, 32'h8000_0004, 32'h1D7);
      rd(0, 1, 32'h0000_000D, "R2 R3 istatus");
      rd(1, 0, 32'h0,         "R2 dstatus untouched");
      rd(2, 1, 32'h1000_0040, "R4 iaddr");
      rd(3, 0, 32'h0,         "R4 daddr untouched");
      rd(4, 1, 32'h0000_0005, "R5 R7 iaux way masked");
      rd(6, 1, 32'h8000_0004, "R1 return");
      rd(7, 1, 32'h0000_01D7, "R1 state");

      // synchronous data-side write abort in the cache
      ev_sync(1, 0, 1, 5'h08, 32'h2000_0100, 0, 2'd0, 2'd3, 32'h8000_0100, 32'h1D3);
      rd(1, 1, 32'h0000_0028, "R2 dstatus");
      rd(3, 1, 32'h2000_0100, "R4 daddr");
      rd(5, 1, 32'h0000_0030, "R5 daux no set");
      rd(0, 1, 32'h0000_000D, "R2 istatus kept");

      // asynchronous cache error
      ev_async(1, 5'h16, 1, 2'd0, 8'h3C, 2'd2, 32'h9000_0000, 32'h117);
      rd(1, 1, 32'h0000_0076, "R3 R6 dstatus async");
      rd(5, 1, 32'h0000_3C21, "R7 daux set and way");
      rd(3, 1, 32'h2000_0100, "R6 daddr kept");
      rd(0, 1, 32'h0000_000D, "R6 istatus kept");
      rd(2, 1, 32'h1000_0040, "R6 iaddr kept");
      rd(4, 1, 32'h0000_0005, "R6 iaux kept");
      rd(6, 1, 32'h9000_0000, "R1 return async");
      rd(7, 1, 32'h0000_0117, "R1 state async");

      // asynchronous error in memory B: way and set read zero
      ev_async(0, 5'h06, 0, 2'd3, 8'h11, 2'd1, 32'h9000_0010, 32'h117);
      rd(5, 1, 32'h0000_0006, "R7 daux masked");
      rd(1, 1, 32'h0000_0046, "R3 dstatus async");

      // debug event on the instruction side
      ev_sync(0, 1, 0, 5'h02, 32'hDEAD_0000, 1, 2'd0, 2'd2, 32'h7000_0000, 32'h1DF);
      rd(0, 1, 32'h0000_0082, "R3 R8 debug class");
      rd(2, 1, 32'h1000_0040, "R8 iaddr kept");
      rd(4, 1, 32'h0000_0005, "R8 iaux kept");
      rd(6, 1, 32'h7000_0000, "R1 R8 return");

      // handler writes
      hw_write(0);
      rd(0, 0, 32'h0000_0082, "R9 clear istatus");
      hw_write(2);
      rd(2, 1, 32'h1000_0040, "R9 write to address ignored");
      hw_write(1);
      rd(1, 0, 32'h0000_0046, "R9 clear dstatus");

      // both channels in the same cycle
      ev_sync(0, 0, 0, 5'h01, 32'h0000_4000, 1, 2'd1, 2'd0, 32'h0000_000A, 32'h1);
      set_async(0, 5'h19, 0, 2'd0, 8'h20, 2'd1);
      rd(6, 1, 32'h0000_000A, "R10 sync return first");
      exc_ret_addr = 32'h0000_000B; exc_state = 32'h2;
      rd(6, 1, 32'h0000_000B, "R10 deferred async return");
      rd(7, 1, 32'h0000_0002, "R10 deferred async state");
      rd(1, 1, 32'h0000_0059, "R10 dstatus async");
      rd(5, 1, 32'h0000_2010, "R10 daux async");
      rd(0, 1, 32'h0000_0001, "R10 istatus sync");
      rd(2, 1, 32'h0000_4000, "R10 iaddr sync");
      rd(4, 1, 32'h0000_0003, "R10 iaux sync");

      // capture and clear on the same status word
      ev_sync(1, 0, 0, 5'h03, 32'h0000_5000, 0, 2'd2, 2'd0, 32'h0000_0C00, 32'h3);
      wr_en = 1; wr_sel = 3'd1;
      rd(1, 1, 32'h0000_0003, "R9 capture beats clear");
      rd(3, 1, 32'h0000_5000, "R4 R11 daddr");

      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule